// File: doc/BRIEF.md
# Processor Bus Takeover Controller

This block lets a host take the external address and data bus away from an 8-bit microprocessor and give it back, while also owning the processor's reset line. The processor is steered through three lines: an active-low bus request output, an active-low bus acknowledge input, and a reset output. The reset output has a polarity that is learned from the line level present while the block is in reset. The block keeps one of four states: processor held in reset, held in reset with the bus taken, processor running, or running with the bus taken. It enables the host's bus drivers only while the bus is taken.

Commands arrive over a valid/ready pair carrying a 3-bit code. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` falls in the cycle after a command that must wait for the processor: a bus take, a bus hand-back, a reset command, a reset pulse or a momentary release. It stays low until that wait ends. While `cmd_ready` is low, `cmd_valid` is ignored and the command is not held. Waits are bounded by a count of prescaled ticks. When the bus is taken out of reset, the block measures how long the processor took to acknowledge and keeps that count on an output.

Top module: `bus_takeover_ctrl`

## Requirements
- R1: After `rst_n` is released, the block shows state 0 and `acquired` low. In that condition `cmd_ready` is high, `busreq_n` is high, `bus_drv_en` is low, `ack_cycles` is 0 and the processor reset is asserted. State codes: 0 = reset, 1 = reset with bus, 2 = running, 3 = running with bus. `acquired` is bit 0 of the state.
- R2: The level of `rst_level_in` sampled while `rst_n` is low is the asserted level of `cpu_rst`. The released level is its inverse, and later changes of `rst_level_in` have no effect.
- R3: Request (code 1) from state 0 drives `busreq_n` low and releases reset in the cycle after acceptance. Once the processor acknowledges, state becomes 1 and `bus_drv_en` goes high. `bus_drv_en` is never high while `busreq_n` is high.
- R4: If no acknowledge arrives for a Request from state 0, the wait ends REQ_RST_TICKS ticks after acceptance, with a tick every TICK_DIV clocks. At that point reset is asserted again, `busreq_n` goes high and state stays 0.
- R5: On a Request from state 0, `ack_cycles` is cleared and then counts every clock of the wait, including the edge that ends it. `busack_n` passes through two synchronising flops, so an acknowledge arriving k cycles after acceptance gives k+3.
- R6: Request from state 2 goes to state 3 with drivers on if acknowledged. Otherwise it ends after REQ_RUN_TICKS ticks with `busreq_n` high and state 2.
- R7: Release (code 2) from state 1 turns the drivers off, asserts reset, raises `busreq_n` and goes to state 0. From state 3 it does the same but leaves reset alone and goes to state 2. `cmd_ready` returns once the acknowledge is seen released, or after DROP_TICKS ticks.
- R8: Run (code 3) from state 0 releases reset at once and goes to state 2. From state 1 it turns the drivers off and pulses reset for PULSE_CYC cycles, then turns the drivers back on in state 3.
- R9: Restart (code 4) in state 2 or 3 asserts reset for exactly PULSE_CYC cycles and leaves state and drivers unchanged.
- R10: Reset (code 0) from any state goes to state 0 at once, with drivers off, reset asserted and `busreq_n` high. `cmd_ready` returns when the acknowledge is seen released, or after DROP_TICKS ticks.
- R11: A command not defined for the current state is accepted with no effect on any output, as are codes 6 and 7.
- R12: A command offered while `cmd_ready` is low is dropped and changes nothing.
- R13: Momentary release (code 5) in state 3 turns the drivers off and raises `busreq_n`. Once the acknowledge is released it lowers `busreq_n` again, and on the next acknowledge it turns the drivers back on, still in state 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_code | input | 3 | Command code |
| busack_n | input | 1 | Processor bus acknowledge, active low, asynchronous |
| rst_level_in | input | 1 | Reset line level, sampled during block reset to learn polarity |
| cpu_rst | output | 1 | Processor reset line |
| busreq_n | output | 1 | Processor bus request, active low |
| bus_drv_en | output | 1 | Enable for host address, data and strobe drivers |
| state | output | 2 | Current state code |
| acquired | output | 1 | Bus is held by the host |
| ack_cycles | output | LAT_W | Measured acknowledge latency |

## Verification
The hardest behaviour to reach is the end of a bounded wait. A timeout only shows after hundreds of prescaled ticks, and then only if the acknowledge is held off for exactly that long. The bench therefore runs with a small tick divider. It keeps `busack_n` still and checks `cmd_ready` on the cycle before and the cycle of the predicted timeout edge. In the middle of that wait it offers a command that would change the state, to show it is dropped. The latency count is swept over several acknowledge delays, and each expected value comes from the delay plus the synchroniser depth.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    ST_RESET     = 2'd0,
    ST_RESET_ACQ = 2'd1,
    ST_RUN       = 2'd2,
    ST_RUN_ACQ   = 2'd3
  } bt_state_e;

  typedef enum logic [2:0] {
    CMD_RESET   = 3'd0,
    CMD_REQUEST = 3'd1,
    CMD_RELEASE = 3'd2,
    CMD_RUN     = 3'd3,
    CMD_RESTART = 3'd4,
    CMD_MCYCLE  = 3'd5
  } bt_cmd_e;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_ACQ,
    OP_DROP,
    OP_HOP,
    OP_PULSE
  } bt_op_e;
endpackage

// File: rtl/bt_sync2.sv
module bt_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/bt_tick.sv
module bt_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic strobe
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign strobe = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (strobe)       cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // ticks are isolated pulses, so a timeout window counts whole periods
  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/bt_latcnt.sv
module bt_latcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) count <= '0;
    else if (inc)      count <= count + 1'b1;
  end

  assert_lat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(count));
endmodule

// File: rtl/bt_fsm.sv
module bt_fsm
  import bt_pkg::*;
#(
  parameter int REQ_RST_TICKS = 255,
  parameter int REQ_RUN_TICKS = 20,
  parameter int DROP_TICKS    = 20,
  parameter int PULSE_CYC     = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  output logic       cmd_ready,
  input  logic       ack,
  input  logic       tick,
  output logic       tick_restart,
  output logic       lat_clr,
  output logic       lat_inc,
  output bt_state_e  st,
  output logic       rst_a,
  output logic       req_n,
  output logic       drv
);
  localparam int T_A  = (REQ_RST_TICKS > REQ_RUN_TICKS) ? REQ_RST_TICKS : REQ_RUN_TICKS;
  localparam int T_MX = (T_A > DROP_TICKS) ? T_A : DROP_TICKS;
  localparam int TW   = $clog2(T_MX + 1);
  localparam int PW   = (PULSE_CYC > 1) ? $clog2(PULSE_CYC + 1) : 1;

  bt_op_e        op;
  logic [TW-1:0] tmr;
  logic [PW-1:0] pcnt;
  logic          from_rst;
  logic          relink;
  logic          accept;
  logic          timeout;
  logic          hop_done;

  assign cmd_ready    = (op == OP_IDLE);
  assign accept       = cmd_valid && cmd_ready;
  assign timeout      = tick && (tmr == TW'(1));
  assign hop_done     = (op == OP_HOP) && (!ack || timeout);
  assign tick_restart = (op == OP_IDLE) || hop_done;
  assign lat_clr      = accept && (cmd_code == CMD_REQUEST) && (st == ST_RESET);
  assign lat_inc      = (op == OP_ACQ) && from_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_RESET;
      op       <= OP_IDLE;
      rst_a    <= 1'b1;
      req_n    <= 1'b1;
      drv      <= 1'b0;
      tmr      <= '0;
      pcnt     <= '0;
      from_rst <= 1'b0;
      relink   <= 1'b0;
    end else begin
      if (tick && op != OP_IDLE && tmr != '0) tmr <= tmr - 1'b1;
      case (op)
        OP_IDLE: begin
          if (cmd_valid) begin
            case (cmd_code)
              CMD_RESET: begin
                drv   <= 1'b0;
                rst_a <= 1'b1;
                req_n <= 1'b1;
                st    <= ST_RESET;
                tmr   <= TW'(DROP_TICKS);
                op    <= OP_DROP;
              end
              CMD_REQUEST: begin
                if (st == ST_RESET) begin
                  req_n    <= 1'b0;
                  rst_a    <= 1'b0;
                  from_rst <= 1'b1;
                  tmr      <= TW'(REQ_RST_TICKS);
                  op       <= OP_ACQ;
                end else if (st == ST_RUN) begin
                  req_n    <= 1'b0;
                  from_rst <= 1'b0;
                  tmr      <= TW'(REQ_RUN_TICKS);
                  op       <= OP_ACQ;
                end
              end
              CMD_RELEASE: begin
                if (st[0]) begin
                  drv   <= 1'b0;
                  req_n <= 1'b1;
                  tmr   <= TW'(DROP_TICKS);
                  op    <= OP_DROP;
                  if (st == ST_RESET_ACQ) begin
                    rst_a <= 1'b1;
                    st    <= ST_RESET;
                  end else begin
                    st    <= ST_RUN;
                  end
                end
              end
              CMD_RUN: begin
                if (st == ST_RESET) begin
                  rst_a <= 1'b0;
                  st    <= ST_RUN;
                end else if (st == ST_RESET_ACQ) begin
                  drv    <= 1'b0;
                  rst_a  <= 1'b1;
                  pcnt   <= PW'(PULSE_CYC - 1);
                  relink <= 1'b1;
                  op     <= OP_PULSE;
                end
              end
              CMD_RESTART: begin
                if (st[1]) begin
                  rst_a  <= 1'b1;
                  pcnt   <= PW'(PULSE_CYC - 1);
                  relink <= 1'b0;
                  op     <= OP_PULSE;
                end
              end
              CMD_MCYCLE: begin
                if (st == ST_RUN_ACQ) begin
                  drv   <= 1'b0;
                  req_n <= 1'b1;
                  tmr   <= TW'(DROP_TICKS);
                  op    <= OP_HOP;
                end
              end
              default: ;
            endcase
          end
        end
        OP_ACQ: begin
          if (ack) begin
            drv <= 1'b1;
            st  <= from_rst ? ST_RESET_ACQ : ST_RUN_ACQ;
            op  <= OP_IDLE;
          end else if (timeout) begin
            req_n <= 1'b1;
            if (from_rst) rst_a <= 1'b1;
            st    <= from_rst ? ST_RESET : ST_RUN;
            op    <= OP_IDLE;
          end
        end
        OP_DROP: begin
          if (!ack || timeout) op <= OP_IDLE;
        end
        OP_HOP: begin
          if (hop_done) begin
            req_n    <= 1'b0;
            from_rst <= 1'b0;
            tmr      <= TW'(REQ_RUN_TICKS);
            op       <= OP_ACQ;
          end
        end
        OP_PULSE: begin
          if (pcnt == '0) begin
            rst_a <= 1'b0;
            op    <= OP_IDLE;
            if (relink) begin
              drv <= 1'b1;
              st  <= ST_RUN_ACQ;
            end
          end else begin
            pcnt <= pcnt - 1'b1;
          end
        end
        default: op <= OP_IDLE;
      endcase
    end
  end

  assert_drv_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> !req_n);
  assert_idle_acq_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE && st[0]) |-> drv);
  assert_idle_reset_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE && st == ST_RESET) |-> rst_a);
  assert_reset_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_code == CMD_RESET) |=> (st == ST_RESET && rst_a && req_n && !drv));
  assert_restart_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_code == CMD_RESTART) |=> $stable(st));
  assert_busy_no_state_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DROP) |=> $stable(st));
endmodule

// File: rtl/bus_takeover_ctrl.sv
module bus_takeover_ctrl
  import bt_pkg::*;
#(
  parameter int TICK_DIV      = 10_000_000,
  parameter int REQ_RST_TICKS = 255,
  parameter int REQ_RUN_TICKS = 20,
  parameter int DROP_TICKS    = 20,
  parameter int PULSE_CYC     = 1000,
  parameter int LAT_W         = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_code,
  input  logic             busack_n,
  input  logic             rst_level_in,
  output logic             cpu_rst,
  output logic             busreq_n,
  output logic             bus_drv_en,
  output logic [1:0]       state,
  output logic             acquired,
  output logic [LAT_W-1:0] ack_cycles
);
  logic      ack_n_s;
  logic      tick;
  logic      tick_restart;
  logic      lat_clr;
  logic      lat_inc;
  logic      rst_a;
  logic      pol_hi;
  bt_state_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) pol_hi <= rst_level_in;
  end

  bt_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(busack_n), .q(ack_n_s)
  );

  bt_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(tick_restart), .strobe(tick)
  );

  bt_latcnt #(.W(LAT_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .clr(lat_clr), .inc(lat_inc), .count(ack_cycles)
  );

  bt_fsm #(
    .REQ_RST_TICKS(REQ_RST_TICKS),
    .REQ_RUN_TICKS(REQ_RUN_TICKS),
    .DROP_TICKS(DROP_TICKS),
    .PULSE_CYC(PULSE_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_ready(cmd_ready),
    .ack(!ack_n_s), .tick(tick), .tick_restart(tick_restart),
    .lat_clr(lat_clr), .lat_inc(lat_inc),
    .st(st), .rst_a(rst_a), .req_n(busreq_n), .drv(bus_drv_en)
  );

  assign cpu_rst  = pol_hi ? rst_a : !rst_a;
  assign state    = st;
  assign acquired = st[0];

  assert_polarity_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(pol_hi));
endmodule

// File: tb/sim_bus_takeover_ctrl.sv
module sim_bus_takeover_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int TR    = 255;
  localparam int TN    = 20;
  localparam int TD    = 20;
  localparam int PULSE = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_code = 3'd0;
  logic        busack_n = 1'b1;
  logic        rst_level_in = 1'b0;
  logic        cpu_rst;
  logic        busreq_n;
  logic        bus_drv_en;
  logic [1:0]  state;
  logic        acquired;
  logic [31:0] ack_cycles;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic asrt;
  logic rel;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_takeover_ctrl #(
    .TICK_DIV(DIV), .REQ_RST_TICKS(TR), .REQ_RUN_TICKS(TN),
    .DROP_TICKS(TD), .PULSE_CYC(PULSE), .LAT_W(32)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .busack_n(busack_n), .rst_level_in(rst_level_in),
    .cpu_rst(cpu_rst), .busreq_n(busreq_n), .bus_drv_en(bus_drv_en),
    .state(state), .acquired(acquired), .ack_cycles(ack_cycles)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] code);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic lvl);
    rst_level_in = lvl;
    rst_n = 1'b0;
    waitn(3);
    rst_n = 1'b1;
    asrt = lvl;
    rel  = ~lvl;
    @(negedge clk);
  endtask

  initial begin
    do_reset(1'b0);
    // R1 reset state, R2 polarity low
    chk("R1 state", state, 0);
    chk("R1 acquired", acquired, 0);
    chk("R1 ready", cmd_ready, 1);
    chk("R1 busreq_n", busreq_n, 1);
    chk("R1 drv", bus_drv_en, 0);
    chk("R1 ack_cycles", ack_cycles, 0);
    chk("R2 asserted level", cpu_rst, asrt);

    // R4 timeout from reset, R12 dropped command while busy
    send(3'd1);
    chk("R3 busreq low", busreq_n, 0);
    chk("R3 reset released", cpu_rst, rel);
    waitn(10);
    cmd_valid = 1'b1; cmd_code = 3'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    waitn(TR * DIV - 12);
    chk("R4 still waiting", cmd_ready, 0);
    @(negedge clk);
    chk("R4 ready after timeout", cmd_ready, 1);
    chk("R12 busy command dropped", state, 0);
    chk("R4 busreq dropped", busreq_n, 1);
    chk("R4 reset reasserted", cpu_rst, asrt);
    chk("R5 count on timeout", ack_cycles, TR * DIV);

    // R5 latency sweep, R3 take, R7 release from reset-with-bus
    for (int k = 0; k < 5; k++) begin
      send(3'd1);
      waitn(k);
      busack_n = 1'b0;
      waitn(2);
      chk("R5 not yet seen", cmd_ready, 0);
      @(negedge clk);
      chk("R3 state taken", state, 1);
      chk("R3 drivers on", bus_drv_en, 1);
      chk("R5 latency", ack_cycles, k + 3);
      send(3'd2);
      chk("R7 state", state, 0);
      chk("R7 drivers off", bus_drv_en, 0);
      chk("R7 busreq", busreq_n, 1);
      chk("R7 reset asserted", cpu_rst, asrt);
      busack_n = 1'b1;
      waitn(2);
      chk("R7 waiting drop", cmd_ready, 0);
      @(negedge clk);
      chk("R7 ready after drop", cmd_ready, 1);
    end

    // R8 run from reset
    send(3'd3);
    chk("R8 state run", state, 2);
    chk("R8 reset released", cpu_rst, rel);
    chk("R8 ready", cmd_ready, 1);

    // R6 timeout while running
    send(3'd1);
    waitn(TN * DIV - 1);
    chk("R6 still waiting", cmd_ready, 0);
    @(negedge clk);
    chk("R6 ready after timeout", cmd_ready, 1);
    chk("R6 state stays", state, 2);
    chk("R6 busreq dropped", busreq_n, 1);
    chk("R6 reset untouched", cpu_rst, rel);

    // R6 success while running
    send(3'd1);
    busack_n = 1'b0;
    waitn(3);
    chk("R6 state taken", state, 3);
    chk("R6 drivers on", bus_drv_en, 1);

    // R9 restart with bus held
    send(3'd4);
    chk("R9 pulse start", cpu_rst, asrt);
    waitn(PULSE - 1);
    chk("R9 pulse still on", cpu_rst, asrt);
    @(negedge clk);
    chk("R9 pulse end", cpu_rst, rel);
    chk("R9 state kept", state, 3);
    chk("R9 drivers kept", bus_drv_en, 1);

    // R11 ignored commands
    send(3'd7);
    send(3'd3);
    send(3'd1);
    chk("R11 state", state, 3);
    chk("R11 drivers", bus_drv_en, 1);
    chk("R11 busreq", busreq_n, 0);
    chk("R11 reset", cpu_rst, rel);
    chk("R11 ready", cmd_ready, 1);

    // R13 momentary release
    send(3'd5);
    chk("R13 drivers off", bus_drv_en, 0);
    chk("R13 busreq high", busreq_n, 1);
    busack_n = 1'b1;
    waitn(3);
    chk("R13 busreq low again", busreq_n, 0);
    chk("R13 drivers still off", bus_drv_en, 0);
    busack_n = 1'b0;
    waitn(3);
    chk("R13 drivers back", bus_drv_en, 1);
    chk("R13 state", state, 3);
    chk("R13 ready", cmd_ready, 1);

    // R7 release from running-with-bus
    send(3'd2);
    chk("R7 state run", state, 2);
    chk("R7 reset untouched", cpu_rst, rel);
    chk("R7 drivers off run", bus_drv_en, 0);
    busack_n = 1'b1;
    waitn(3);
    chk("R7 ready run", cmd_ready, 1);

    // R9 restart while running
    send(3'd4);
    waitn(PULSE - 1);
    chk("R9 run pulse on", cpu_rst, asrt);
    @(negedge clk);
    chk("R9 run pulse off", cpu_rst, rel);
    chk("R9 run state", state, 2);

    // R10 reset command, ack already released
    send(3'd0);
    chk("R10 state", state, 0);
    chk("R10 reset asserted", cpu_rst, asrt);
    chk("R10 busreq", busreq_n, 1);
    @(negedge clk);
    chk("R10 ready fast", cmd_ready, 1);

    // R8 run from reset-with-bus
    send(3'd1);
    busack_n = 1'b0;
    waitn(3);
    chk("R5 zero delay", ack_cycles, 3);
    send(3'd3);
    chk("R8 drivers off in pulse", bus_drv_en, 0);
    chk("R8 reset pulsed", cpu_rst, asrt);
    waitn(PULSE);
    chk("R8 state", state, 3);
    chk("R8 drivers on", bus_drv_en, 1);
    chk("R8 reset released", cpu_rst, rel);

    // R10 reset command with ack held: bounded wait
    send(3'd0);
    chk("R10 drivers off", bus_drv_en, 0);
    waitn(TD * DIV - 1);
    chk("R10 still waiting", cmd_ready, 0);
    @(negedge clk);
    chk("R10 ready after timeout", cmd_ready, 1);
    chk("R10 state", state, 0);
    busack_n = 1'b1;
    waitn(3);

    // R2 active-high polarity
    do_reset(1'b1);
    chk("R2 high asserted", cpu_rst, 1);
    rst_level_in = 1'b0;
    send(3'd3);
    chk("R2 high released", cpu_rst, 0);
    send(3'd4);
    chk("R2 high pulse", cpu_rst, 1);
    waitn(PULSE);
    chk("R2 high pulse end", cpu_rst, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule